// File: doc/BRIEF.md
# Multicart Outer Bank Controller

This block holds the outer banking configuration of a cartridge that can take on one of three personalities around one shared program and pattern memory. Two inner mapper cores run beside it: a command-register style core (called the "primary core" here) and an alternate ASIC-style core. The block also offers a plain unbanked 32 KB program mode. CPU stores into a 4 KB register window load four 8-bit configuration registers. From these registers the block derives the active personality and a one-cycle reset pulse for the core being switched in. It also forms the final program (8 KB units) and pattern (1 KB units) bank numbers. It does this by masking the bank index that the active inner core supplies and filling the remaining upper bits from outer configuration bits.

The inner cores, interrupt logic, mirroring and the memories are not part of the block. Each inner core appears only as a program bank index input and a pattern bank index input. The bank outputs are combinational in the registers and the inner indices, so a change of inner index is seen in the same cycle. The mode flag and the reset pulses are registered.

Top module: `outer_bank_ctrl`

## Requirements
- R1: After synchronous reset the four registers hold reg0=0x00, reg1=0x0F, reg2=0x00, reg3=0x10, and both core reset pulses are low.
- R2: A write with `wr_en` high and `wr_addr` in 0x5000..0x5FFF loads `wr_data` into the register numbered by `wr_addr[1:0]`. A write at any other address changes no register and no output. Writes to reg0 and reg2 change no output.
- R3: `mode_asic` equals reg1 bit 4. A value of 1 selects the ASIC-style core and 0 selects the primary core. `mode_asic` updates on the clock edge that takes the write.
- R4: A write that takes reg1 bit 4 from 0 to 1 raises `asic_core_rst` for exactly the one cycle after that edge. A write that takes it from 1 to 0 does the same on `mmc_core_rst`. A write that leaves the bit unchanged pulses neither output.
- R5: The program outer value has reg3 bit 3 at bit 4 and reg1 bit 0 at bit 5, with all other bits zero. The pattern outer value has reg3 bit 6 at bit 7 and reg1 bit 0 at bit 8, with all other bits zero.
- R6: In primary mode with reg1 bit 3 set, `prg_bank` = (`mmc_prg_idx` AND m) OR (program outer AND NOT m), taken over 6 bits. The mask m is 0x1F when reg3 bit 4 is set and 0x0F otherwise. `prg_32k` is 0.
- R7: In primary mode with reg1 bit 3 clear, `prg_32k` is 1. `prg_bank` = {B, `prg_slot`}, where B is the 4-bit value (program outer OR (reg3[2:0] shifted left by 1)) shifted right by 2.
- R8: In primary mode, `chr_bank` = (`mmc_chr_idx` AND m) OR (pattern outer AND NOT m), taken over 9 bits. The mask m is 0xFF when reg3 bit 7 is set and 0x7F otherwise.
- R9: In ASIC mode, `prg_bank` uses `asic_prg_idx` with a fixed mask of 0x1F, and `chr_bank` uses `asic_chr_idx` with a fixed mask of 0xFF, each filled with its outer value. `prg_32k` is 0.
- R10: `prg_bank` and `chr_bank` follow changes of the inner indices and of `prg_slot` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_slot | input | 2 | 8 KB slot within the 32 KB program window |
| mmc_prg_idx | input | 8 | Program bank index from the primary core |
| asic_prg_idx | input | 8 | Program bank index from the ASIC-style core |
| mmc_chr_idx | input | 8 | Pattern bank index from the primary core |
| asic_chr_idx | input | 8 | Pattern bank index from the ASIC-style core |
| mode_asic | output | 1 | 1 when the ASIC-style core is active |
| asic_core_rst | output | 1 | One-cycle reset for the ASIC-style core |
| mmc_core_rst | output | 1 | One-cycle reset for the primary core |
| prg_32k | output | 1 | 1 when the unbanked 32 KB program mode is in force |
| prg_bank | output | 6 | Final 8 KB program bank number |
| chr_bank | output | 9 | Final 1 KB pattern bank number |

## Verification
Every value of reg3 is combined with each setting of reg1 bits 0, 3 and 4, with noise in the unused reg1 bits. This covers each mask width, each outer bit and each of the three program layouts. Under each setting, the four inner indices carry different values, so a bank taken from the wrong core, or a mask that is one bit too wide or too narrow, shows as a wrong number. All four slot values are also used, which separates the 32 KB slot concatenation from the banked path. Writes just outside the window, aliased addresses inside it, repeated writes of the same mode bit, and toggles in both directions tell the window decode and the edge detection apart from a plain level copy.

// File: rtl/obc_pkg.sv
package obc_pkg;
  localparam int OBC_NREGS = 4;
  localparam int OBC_SEL_W = 2;
  typedef logic [7:0] obc_reg_t;
  localparam obc_reg_t OBC_RESET_VAL [OBC_NREGS] = '{8'h00, 8'h0F, 8'h00, 8'h10};
  // register numbers whose contents drive behaviour
  localparam int OBC_MODE_REG = 1;
  localparam int OBC_CFG_REG  = 3;
  // bit positions inside the mode register
  localparam int OBC_ASIC_BIT  = 4;
  localparam int OBC_PRG8K_BIT = 3;
  localparam int OBC_OUTHI_BIT = 0;
  // bit positions inside the config register
  localparam int OBC_CHRWIDE_BIT = 7;
  localparam int OBC_CHROUT_BIT  = 6;
  localparam int OBC_PRGWIDE_BIT = 4;
  localparam int OBC_PRGOUT_BIT  = 3;
endpackage

// File: rtl/obc_regfile.sv
module obc_regfile
  import obc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h5000,
  parameter int WIN_SPAN = 'h1000
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [7:0]                          wr_data,
  output logic [OBC_NREGS-1:0][7:0]           regs_q,
  output logic [OBC_NREGS-1:0]                hit
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_SPAN - 1);

  logic win_hit;
  assign win_hit = wr_en && (wr_addr >= WIN_LO) && (wr_addr <= WIN_HI);

  for (genvar g = 0; g < OBC_NREGS; g++) begin : g_sel
    assign hit[g] = win_hit && (wr_addr[OBC_SEL_W-1:0] == OBC_SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < OBC_NREGS; i++) begin
      if (rst)         regs_q[i] <= OBC_RESET_VAL[i];
      else if (hit[i]) regs_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/obc_mode_pulse.sv
module obc_mode_pulse (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic mode_new,
  input  logic mode_cur,
  output logic asic_rst_o,
  output logic mmc_rst_o
);
  logic rise, fall;
  assign rise = mode_wr &&  mode_new && !mode_cur;
  assign fall = mode_wr && !mode_new &&  mode_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      asic_rst_o <= 1'b0;
      mmc_rst_o  <= 1'b0;
    end else begin
      asic_rst_o <= rise;
      mmc_rst_o  <= fall;
    end
  end
endmodule

// File: rtl/obc_prg_map.sv
module obc_prg_map #(
  parameter int BANK_W = 6,
  parameter int SLOT_W = 2
) (
  input  logic              asic_mode,
  input  logic              banked_8k,
  input  logic              outer_hi,
  input  logic              outer_lo,
  input  logic              wide_mask,
  input  logic [2:0]        rom_sel,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BANK_W-1:0] mmc_idx,
  input  logic [BANK_W-1:0] asic_idx,
  output logic [BANK_W-1:0] bank,
  output logic              is_32k
);
  localparam logic [BANK_W-1:0] MASK_WIDE   = BANK_W'(8'h1F);
  localparam logic [BANK_W-1:0] MASK_NARROW = BANK_W'(8'h0F);
  localparam int              BLK_W       = BANK_W - SLOT_W;

  logic [BANK_W-1:0] outer, mask, inner, merged, combo, blk;

  always_comb begin
    outer    = '0;
    outer[4] = outer_lo;
    outer[5] = outer_hi;
  end

  assign mask   = (asic_mode || wide_mask) ? MASK_WIDE : MASK_NARROW;
  assign inner  = asic_mode ? asic_idx : mmc_idx;
  assign merged = (inner & mask) | (outer & ~mask);
  assign combo  = outer | BANK_W'({rom_sel, 1'b0});
  assign blk    = combo >> 2;
  assign is_32k = !asic_mode && !banked_8k;
  assign bank   = is_32k ? {blk[BLK_W-1:0], slot} : merged;
endmodule

// File: rtl/obc_chr_map.sv
module obc_chr_map #(
  parameter int BANK_W = 9
) (
  input  logic              asic_mode,
  input  logic              outer_hi,
  input  logic              outer_lo,
  input  logic              wide_mask,
  input  logic [7:0]        mmc_idx,
  input  logic [7:0]        asic_idx,
  output logic [BANK_W-1:0] bank
);
  localparam logic [BANK_W-1:0] MASK_WIDE   = BANK_W'(8'hFF);
  localparam logic [BANK_W-1:0] MASK_NARROW = BANK_W'(8'h7F);

  logic [BANK_W-1:0] outer, mask, inner;

  always_comb begin
    outer    = '0;
    outer[7] = outer_lo;
    outer[8] = outer_hi;
  end

  assign mask  = (asic_mode || wide_mask) ? MASK_WIDE : MASK_NARROW;
  assign inner = BANK_W'(asic_mode ? asic_idx : mmc_idx);
  assign bank  = (inner & mask) | (outer & ~mask);
endmodule

// File: rtl/outer_bank_ctrl.sv
module outer_bank_ctrl
  import obc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h5000,
  parameter int WIN_SPAN = 'h1000,
  parameter int IDX_W    = 8,
  parameter int PRG_W    = 6,
  parameter int CHR_W    = 9,
  parameter int SLOT_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SLOT_W-1:0] prg_slot,
  input  logic [IDX_W-1:0]  mmc_prg_idx,
  input  logic [IDX_W-1:0]  asic_prg_idx,
  input  logic [IDX_W-1:0]  mmc_chr_idx,
  input  logic [IDX_W-1:0]  asic_chr_idx,
  output logic              mode_asic,
  output logic              asic_core_rst,
  output logic              mmc_core_rst,
  output logic              prg_32k,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank
);
  logic [OBC_NREGS-1:0][7:0] regs_q;
  logic [OBC_NREGS-1:0]      hit;
  obc_reg_t                  mode_r, cfg_r;

  obc_regfile #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_q(regs_q), .hit(hit)
  );

  assign mode_r    = regs_q[OBC_MODE_REG];
  assign cfg_r     = regs_q[OBC_CFG_REG];
  assign mode_asic = mode_r[OBC_ASIC_BIT];

  obc_mode_pulse u_pulse (
    .clk(clk), .rst(rst),
    .mode_wr(hit[OBC_MODE_REG]), .mode_new(wr_data[OBC_ASIC_BIT]), .mode_cur(mode_asic),
    .asic_rst_o(asic_core_rst), .mmc_rst_o(mmc_core_rst)
  );

  obc_prg_map #(.BANK_W(PRG_W), .SLOT_W(SLOT_W)) u_prg (
    .asic_mode(mode_asic), .banked_8k(mode_r[OBC_PRG8K_BIT]),
    .outer_hi(mode_r[OBC_OUTHI_BIT]), .outer_lo(cfg_r[OBC_PRGOUT_BIT]),
    .wide_mask(cfg_r[OBC_PRGWIDE_BIT]), .rom_sel(cfg_r[2:0]), .slot(prg_slot),
    .mmc_idx(mmc_prg_idx[PRG_W-1:0]), .asic_idx(asic_prg_idx[PRG_W-1:0]),
    .bank(prg_bank), .is_32k(prg_32k)
  );

  obc_chr_map #(.BANK_W(CHR_W)) u_chr (
    .asic_mode(mode_asic), .outer_hi(mode_r[OBC_OUTHI_BIT]), .outer_lo(cfg_r[OBC_CHROUT_BIT]),
    .wide_mask(cfg_r[OBC_CHRWIDE_BIT]), .mmc_idx(mmc_chr_idx[7:0]), .asic_idx(asic_chr_idx[7:0]),
    .bank(chr_bank)
  );

  logic unused_ok;
  assign unused_ok = ^{regs_q[0], regs_q[2], mode_r[7:5], mode_r[2:1], cfg_r[5],
                       hit[0], hit[2], hit[3],
                       mmc_prg_idx[IDX_W-1:PRG_W], asic_prg_idx[IDX_W-1:PRG_W]};
endmodule

// File: rtl/obc_checker.sv
module obc_checker #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BASE = 'h5000,
  parameter int WIN_SPAN = 'h1000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        prg_slot,
  input logic [7:0]        asic_prg_idx,
  input logic [7:0]        asic_chr_idx,
  input logic              mode_asic,
  input logic              asic_core_rst,
  input logic              mmc_core_rst,
  input logic              prg_32k,
  input logic [5:0]        prg_bank,
  input logic [8:0]        chr_bank
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + WIN_SPAN - 1);

  logic out_win;
  assign out_win = wr_en && ((wr_addr < WIN_LO) || (wr_addr > WIN_HI));

  assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    out_win |=> $stable(mode_asic));
  assert_asic_pulse_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_asic) |-> asic_core_rst);
  assert_mmc_pulse_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_asic) |-> mmc_core_rst);
  assert_asic_pulse_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    asic_core_rst |-> $rose(mode_asic));
  assert_mmc_pulse_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    mmc_core_rst |-> $fell(mode_asic));
  assert_pulse_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({asic_core_rst, mmc_core_rst}));
  assert_slot_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
    prg_32k |-> (prg_bank[1:0] == prg_slot));
  assert_asic_prg_inner_R9: assert property (@(posedge clk) disable iff (rst)
    mode_asic |-> (prg_bank[4:0] == asic_prg_idx[4:0] && !prg_32k));
  assert_asic_chr_inner_R9: assert property (@(posedge clk) disable iff (rst)
    mode_asic |-> (chr_bank[7:0] == asic_chr_idx));

  logic unused_chk;
  assign unused_chk = ^{asic_prg_idx[7:5], prg_bank[5], chr_bank[8]};
endmodule

bind outer_bank_ctrl obc_checker #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .prg_slot(prg_slot),
  .asic_prg_idx(asic_prg_idx), .asic_chr_idx(asic_chr_idx), .mode_asic(mode_asic),
  .asic_core_rst(asic_core_rst), .mmc_core_rst(mmc_core_rst), .prg_32k(prg_32k),
  .prg_bank(prg_bank), .chr_bank(chr_bank)
);

// File: tb/tb_outer_bank_ctrl.sv
`timescale 1ns/1ps
module tb_outer_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  prg_slot = '0;
  logic [7:0]  mmc_prg_idx = '0, asic_prg_idx = '0, mmc_chr_idx = '0, asic_chr_idx = '0;
  logic        mode_asic, asic_core_rst, mmc_core_rst, prg_32k;
  logic [5:0]  prg_bank;
  logic [8:0]  chr_bank;

  outer_bank_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prg_slot(prg_slot), .mmc_prg_idx(mmc_prg_idx), .asic_prg_idx(asic_prg_idx),
    .mmc_chr_idx(mmc_chr_idx), .asic_chr_idx(asic_chr_idx), .mode_asic(mode_asic),
    .asic_core_rst(asic_core_rst), .mmc_core_rst(mmc_core_rst), .prg_32k(prg_32k),
    .prg_bank(prg_bank), .chr_bank(chr_bank)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int model [4] = '{8'h00, 8'h0F, 8'h00, 8'h10};

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_prg(int r1, int r3, int mi, int ai, int slot);
    int outer, m;
    outer = (((r3 >> 3) & 1) << 4) | ((r1 & 1) << 5);
    if ((r1 >> 4) & 1) return ((ai & 'h1F) | (outer & ~'h1F)) & 'h3F;
    if ((r1 >> 3) & 1) begin
      m = ((r3 >> 4) & 1) ? 'h1F : 'h0F;
      return ((mi & m) | (outer & ~m)) & 'h3F;
    end
    return ((((outer | ((r3 & 7) << 1)) >> 2) << 2) | slot) & 'h3F;
  endfunction

  function automatic int ref_chr(int r1, int r3, int mi, int ai);
    int outer, m, idx;
    outer = (((r3 >> 6) & 1) << 7) | ((r1 & 1) << 8);
    if ((r1 >> 4) & 1) begin m = 'hFF; idx = ai; end
    else begin m = ((r3 >> 7) & 1) ? 'hFF : 'h7F; idx = mi; end
    return ((idx & m) | (outer & ~m)) & 'h1FF;
  endfunction

  // compare every output against the reference using the current model
  task automatic check_outputs(string tag);
    int r1, r3;
    r1 = model[1]; r3 = model[3];
    check({tag, " R3 mode"}, int'(mode_asic), (r1 >> 4) & 1);
    check({tag, ((r1 >> 4) & 1) ? " R9 prg" : (((r1 >> 3) & 1) ? " R6 prg" : " R7 prg")},
          int'(prg_bank), ref_prg(r1, r3, mmc_prg_idx, asic_prg_idx, prg_slot));
    check({tag, " R7 prg_32k"}, int'(prg_32k), (((r1 >> 4) & 1) == 0 && ((r1 >> 3) & 1) == 0) ? 1 : 0);
    check({tag, ((r1 >> 4) & 1) ? " R9 chr" : " R8 chr"}, int'(chr_bank),
          ref_chr(r1, r3, mmc_chr_idx, asic_chr_idx));
  endtask

  // one bus write; checks the pulse in the cycle right after the taking edge
  task automatic do_write(int addr, int data, bit chk_pulse);
    int old_mode, new_mode;
    bit in_win;
    in_win = (addr >= 'h5000) && (addr <= 'h5FFF);
    old_mode = (model[1] >> 4) & 1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (in_win) model[addr & 3] = data & 'hFF;
    new_mode = (model[1] >> 4) & 1;
    if (chk_pulse) begin
      check("R4 asic pulse", int'(asic_core_rst), (old_mode == 0 && new_mode == 1) ? 1 : 0);
      check("R4 mmc pulse", int'(mmc_core_rst), (old_mode == 1 && new_mode == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset contents seen through the outputs
    mmc_prg_idx = 8'hA7; asic_prg_idx = 8'h5C; mmc_chr_idx = 8'hE3; asic_chr_idx = 8'h1B;
    #1;
    check("R1 asic pulse idle", int'(asic_core_rst), 0);
    check("R1 mmc pulse idle", int'(mmc_core_rst), 0);
    check("R1 prg bank", int'(prg_bank), 'h27);
    check("R1 chr bank", int'(chr_bank), 'h163);
    check_outputs("R1");

    // R2: writes outside the window are dropped
    do_write('h4FFF, 'h1E, 1); check_outputs("R2 below");
    do_write('h6001, 'h10, 1); check_outputs("R2 above");
    do_write('h8003, 'hC7, 1); check_outputs("R2 far");
    check("R2 mode untouched", int'(mode_asic), 0);
    // R2: reg0/reg2 have no effect on outputs
    do_write('h5000, 'hFF, 1); check_outputs("R2 reg0");
    do_write('h5FFE, 'hFF, 1); check_outputs("R2 reg2");

    // R4: edges, repeats, aliased addresses
    do_write('h5AB5, 'h1F, 1);
    @(negedge clk);
    check("R4 asic pulse one cycle", int'(asic_core_rst), 0);
    do_write('h5001, 'h1E, 1);
    do_write('h5FFD, 'h0E, 1);
    @(negedge clk);
    check("R4 mmc pulse one cycle", int'(mmc_core_rst), 0);
    do_write('h5005, 'h0F, 1);
    check_outputs("R4 end");

    // R10: inner index and slot changes seen without a clock edge
    do_write('h5003, 'h12, 1);
    do_write('h5001, 'h07, 1);
    for (int s = 0; s < 4; s++) begin
      prg_slot = 2'(s); #0.5;
      check("R10 slot comb", int'(prg_bank), ref_prg(model[1], model[3], mmc_prg_idx, asic_prg_idx, s));
    end
    do_write('h5001, 'h0F, 1);
    mmc_prg_idx = 8'h1D; mmc_chr_idx = 8'h7E; #0.5;
    check("R10 prg comb", int'(prg_bank), ref_prg(model[1], model[3], 'h1D, asic_prg_idx, prg_slot));
    check("R10 chr comb", int'(chr_bank), ref_chr(model[1], model[3], 'h7E, asic_chr_idx));

    // R5..R9: full sweep of reg3 with each relevant reg1 setting
    for (int c = 0; c < 8; c++) begin
      for (int r3 = 0; r3 < 256; r3++) begin
        int r1v;
        r1v = ((c & 1) ? 'h01 : 0) | ((c & 2) ? 'h08 : 0) | ((c & 4) ? 'h10 : 0) | ((r3 & 3) << 1) | ((r3 & 7) << 5);
        do_write('h5003 + ((r3 & 'h3F) << 4), r3, 0);
        do_write('h5801 + ((r3 & 'h3F) << 4), r1v, 1);
        for (int k = 0; k < 4; k++) begin
          mmc_prg_idx  = 8'((r3 * 7 + k * 61) ^ 8'h95);
          asic_prg_idx = 8'((r3 * 13 + k * 29) ^ 8'h3A);
          mmc_chr_idx  = 8'((r3 * 3 + k * 97) ^ 8'hC6);
          asic_chr_idx = 8'((r3 * 11 + k * 43) ^ 8'h59);
          prg_slot     = 2'(k + r3);
          #0.5;
          check_outputs("R5 sweep");
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule